// File: doc/BRIEF.md
# Parallel Code-Group Interface Adapter

This block sits between a protocol layer and a serializer/deserializer core. It carries 10-bit code groups across one parallel port that runs in one of two formats. In the wide format, a whole code group is captured once per reference cycle at the rising edge. In the half-word double-rate format, only the five low lines are used: the more significant half arrives at the rising edge and the less significant half at the falling edge, and the two are merged into one 10-bit group. On the receive side the block returns whole groups in wide format. In double-rate format it returns the upper half at the rising edge and the lower half at the falling edge, both on the five low lines, with the upper five lines held at zero.

The whole block runs from one bit-rate clock. A counter divides it into reference cycles of ten ticks. The rising edge of the modelled reference clock is tick 0 and its falling edge is tick 5. The transmit path shifts one bit per tick, bit 0 first, and reloads every ten ticks. The receive path collects ten bits per reference cycle, with the first bit received landing in bit 0. A format change is accepted only at tick 0. The first group handled after a change is flagged invalid.

Top module: `pcs_par_adapter`

## Requirements
- R1: In wide format (mode_ddr_i = 0), the value on tx_data_i at tick 0 of reference cycle k is the code group serialized during the ten ticks that start at tick 9 of cycle k.
- R2: In double-rate format (mode_ddr_i = 1 at tick 0), tx_data_i[4:0] at tick 0 becomes group bits [9:5] and tx_data_i[4:0] at tick 5 becomes group bits [4:0]. tx_data_i[9:5] and all other ticks have no effect on the serialized group.
- R3: ser_out_o sends bit 0 of each group first and one bit per tick. It reloads after the tick 9 edge, so bit j of a group is on ser_out_o after edge 9+j.
- R4: In wide format, rx_data_o changes only after the tick 0 edge. It then holds the ten bits received in the previous reference cycle, with the bit sampled at tick 0 in bit 0.
- R5: In double-rate format, rx_data_o[4:0] holds received bits [9:5] after the tick 0 edge and bits [4:0] after the tick 5 edge. rx_data_o[9:5] stays at zero.
- R6: ref_clk_o is high for ticks 0 to 4 and low for ticks 5 to 9 of each ten-tick reference cycle.
- R7: mode_ddr_i is sampled only at tick 0. When it differs from the previous format, rx_valid_o is low for that reference cycle, and ser_valid_o is low while the group captured in that cycle is shifted out. Otherwise both are high.
- R8: A synchronous reset clears ser_out_o, ser_valid_o, rx_data_o and rx_valid_o, selects wide format, and restarts the reference cycle at tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode_ddr_i | input | 1 | 0 selects wide format, 1 selects double-rate half words |
| tx_data_i | input | 10 | Transmit code group or half group from the protocol layer |
| ser_in_i | input | 1 | Serial receive bit stream, first bit is group bit 0 |
| ser_out_o | output | 1 | Serial transmit bit stream, group bit 0 first |
| ser_valid_o | output | 1 | Group now being shifted out is valid |
| rx_data_o | output | 10 | Received group or half group toward the protocol layer |
| rx_valid_o | output | 1 | Group now on rx_data_o is valid |
| ref_clk_o | output | 1 | Modelled reference clock, one tenth of the bit rate |

## Verification
Tick 0 is where two functions meet: the format decision and the capture of the first half or the whole group happen on the same edge. The bench changes the format between neighbouring stimulus rows, including a double-rate row followed at once by a wide row. It also drives the inverse format on every tick other than tick 0 and puts inverted junk on unused lines. It then compares, tick by tick, the serial bits, the received words and halves, and both valid flags against values derived from the stimulus table.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic {
    FMT_WIDE = 1'b0,
    FMT_HALF = 1'b1
  } fmt_e;

endpackage

// File: rtl/pa_phase_gen.sv
module pa_phase_gen
  import pa_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int HALF_W = WORD_W / 2,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_req,
  output logic [CNT_W-1:0] cnt,
  output logic             at_rise,
  output logic             at_fall,
  output logic             at_last,
  output logic             ref_clk,
  output fmt_e             fmt_eff,
  output fmt_e             fmt_q,
  output logic             fmt_same
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FALL_TICK = CNT_W'(HALF_W);

  fmt_e fmt_req;
  assign fmt_req = fmt_e'(mode_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST_TICK) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q <= FMT_WIDE;
    end else if (at_rise) begin
      fmt_q <= fmt_req;
    end
  end

  assign at_rise  = (cnt == '0);
  assign at_fall  = (cnt == FALL_TICK);
  assign at_last  = (cnt == LAST_TICK);
  assign ref_clk  = (cnt < FALL_TICK);
  assign fmt_eff  = at_rise ? fmt_req : fmt_q;
  assign fmt_same = (fmt_req == fmt_q);

endmodule

// File: rtl/pa_tx_capture.sv
module pa_tx_capture
  import pa_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_rise,
  input  logic              at_fall,
  input  fmt_e              fmt_eff,
  input  logic              fmt_same,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word,
  output logic              word_ok
);

  logic [HALF_W-1:0] upper_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word    <= '0;
      upper_q <= '0;
      word_ok <= 1'b0;
    end else begin
      if (at_rise) begin
        word_ok <= fmt_same;
        if (fmt_eff == FMT_WIDE) begin
          word <= din;
        end else begin
          upper_q <= din[HALF_W-1:0];
        end
      end
      if (at_fall && fmt_eff == FMT_HALF) begin
        word <= {upper_q, din[HALF_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/pa_tx_serializer.sv
module pa_tx_serializer #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_last,
  input  logic [WORD_W-1:0] word,
  input  logic              word_ok,
  output logic              ser_out,
  output logic              ser_valid
);

  logic [WORD_W-2:0] rest_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rest_q    <= '0;
      ser_out   <= 1'b0;
      ser_valid <= 1'b0;
    end else if (at_last) begin
      ser_out   <= word[0];
      rest_q    <= word[WORD_W-1:1];
      ser_valid <= word_ok;
    end else begin
      ser_out <= rest_q[0];
      rest_q  <= {1'b0, rest_q[WORD_W-2:1]};
    end
  end

endmodule

// File: rtl/pa_rx_deser.sv
module pa_rx_deser #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_last,
  input  logic              ser_in,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-2:0] gather_q;
  logic [WORD_W-1:0] merged;

  assign merged = {ser_in, gather_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      gather_q <= '0;
      rx_word  <= '0;
    end else begin
      gather_q <= merged[WORD_W-1:1];
      if (at_last) begin
        rx_word <= merged;
      end
    end
  end

endmodule

// File: rtl/pa_rx_present.sv
module pa_rx_present
  import pa_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int HALF_W = WORD_W / 2,
  localparam int PAD_W  = WORD_W - HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_rise,
  input  logic              at_fall,
  input  fmt_e              fmt_eff,
  input  logic              fmt_same,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [WORD_W-1:0] upper_view;
  logic [WORD_W-1:0] lower_view;

  assign upper_view = {{PAD_W{1'b0}}, rx_word[WORD_W-1:PAD_W]};
  assign lower_view = {{PAD_W{1'b0}}, rx_word[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (at_rise) begin
        rx_valid <= fmt_same;
        rx_data  <= (fmt_eff == FMT_WIDE) ? rx_word : upper_view;
      end else if (at_fall && fmt_eff == FMT_HALF) begin
        rx_data <= lower_view;
      end
    end
  end

endmodule

// File: rtl/pcs_par_adapter.sv
module pcs_par_adapter
  import pa_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_ddr_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              ser_in_i,
  output logic              ser_out_o,
  output logic              ser_valid_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              ref_clk_o
);

  logic [CNT_W-1:0]  slot_cnt;
  logic              at_rise;
  logic              at_fall;
  logic              at_last;
  fmt_e              fmt_eff;
  fmt_e              fmt_q;
  logic              fmt_same;
  logic [WORD_W-1:0] tx_word;
  logic              tx_word_ok;
  logic [WORD_W-1:0] rx_word;

  pa_phase_gen #(.WORD_W(WORD_W)) phase_i (
    .clk      (clk),
    .rst      (rst),
    .mode_req (mode_ddr_i),
    .cnt      (slot_cnt),
    .at_rise  (at_rise),
    .at_fall  (at_fall),
    .at_last  (at_last),
    .ref_clk  (ref_clk_o),
    .fmt_eff  (fmt_eff),
    .fmt_q    (fmt_q),
    .fmt_same (fmt_same)
  );

  pa_tx_capture #(.WORD_W(WORD_W)) txcap_i (
    .clk      (clk),
    .rst      (rst),
    .at_rise  (at_rise),
    .at_fall  (at_fall),
    .fmt_eff  (fmt_eff),
    .fmt_same (fmt_same),
    .din      (tx_data_i),
    .word     (tx_word),
    .word_ok  (tx_word_ok)
  );

  pa_tx_serializer #(.WORD_W(WORD_W)) txser_i (
    .clk       (clk),
    .rst       (rst),
    .at_last   (at_last),
    .word      (tx_word),
    .word_ok   (tx_word_ok),
    .ser_out   (ser_out_o),
    .ser_valid (ser_valid_o)
  );

  pa_rx_deser #(.WORD_W(WORD_W)) rxdes_i (
    .clk     (clk),
    .rst     (rst),
    .at_last (at_last),
    .ser_in  (ser_in_i),
    .rx_word (rx_word)
  );

  pa_rx_present #(.WORD_W(WORD_W)) rxpres_i (
    .clk      (clk),
    .rst      (rst),
    .at_rise  (at_rise),
    .at_fall  (at_fall),
    .fmt_eff  (fmt_eff),
    .fmt_same (fmt_same),
    .rx_word  (rx_word),
    .rx_data  (rx_data_o),
    .rx_valid (rx_valid_o)
  );

endmodule

// File: rtl/pa_adapter_chk.sv
module pa_adapter_chk #(
  parameter int WORD_W = 10,
  localparam int HALF_W = WORD_W / 2,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  slot_cnt,
  input logic              fmt_q,
  input logic              ser_out_o,
  input logic              ser_valid_o,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_valid_o
);

  localparam logic [CNT_W-1:0] RISE_SEEN = CNT_W'(1);
  localparam logic [CNT_W-1:0] FALL_SEEN = CNT_W'(HALF_W + 1);

  // R5: half-word receive format never drives the upper lines
  p_rx_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    fmt_q |-> (rx_data_o[WORD_W-1:HALF_W] == '0));

  // R7: the latched format only moves at the reference rising edge
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (slot_cnt != '0) |=> $stable(fmt_q));

  // R7: the transmit valid flag changes only when a new group starts
  p_ser_valid_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    (slot_cnt != '0) |-> $stable(ser_valid_o));

  // R4: receive data moves only just after the rising or falling slot
  p_rx_update_slots_r4: assert property (@(posedge clk) disable iff (rst)
    (slot_cnt != RISE_SEEN && slot_cnt != FALL_SEEN) |-> $stable(rx_data_o));

  // R8: two reset edges in a row leave all data outputs cleared
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d === 1'b1 && rst === 1'b1) begin
      p_reset_clear_r8: assert (ser_out_o == 1'b0 && ser_valid_o == 1'b0 &&
                                rx_data_o == '0 && rx_valid_o == 1'b0);
    end
  end

endmodule

bind pcs_par_adapter pa_adapter_chk #(.WORD_W(WORD_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .slot_cnt    (slot_cnt),
  .fmt_q       (fmt_q),
  .ser_out_o   (ser_out_o),
  .ser_valid_o (ser_valid_o),
  .rx_data_o   (rx_data_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/pcs_par_adapter_tb_top.sv
module pcs_par_adapter_tb_top;

  localparam int W    = 10;
  localparam int H    = W / 2;
  localparam int NV   = 12;
  localparam int NCYC = NV + 2;

  // each row: {format, code group}
  localparam logic [W:0] VEC [NV] = '{
    {1'b0, 10'h2A5}, {1'b0, 10'h0F1}, {1'b0, 10'h3C3},
    {1'b1, 10'h155}, {1'b1, 10'h2E7}, {1'b1, 10'h01F},
    {1'b1, 10'h3E0}, {1'b0, 10'h1B4}, {1'b0, 10'h3FF},
    {1'b1, 10'h24A}, {1'b0, 10'h11D}, {1'b0, 10'h2C6}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_ddr = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         ser_line;
  logic         ser_valid;
  logic [W-1:0] rx_data;
  logic         rx_valid;
  logic         ref_clk;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] w_exp [NCYC];
  logic         m_exp [NCYC];
  logic         v_exp [NCYC];

  always #4 clk = ~clk;

  pcs_par_adapter #(.WORD_W(W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .mode_ddr_i  (mode_ddr),
    .tx_data_i   (tx_data),
    .ser_in_i    (ser_line),
    .ser_out_o   (ser_line),
    .ser_valid_o (ser_valid),
    .rx_data_o   (rx_data),
    .rx_valid_o  (rx_valid),
    .ref_clk_o   (ref_clk)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_reset_state();
    chk("R8 ser_out", W'(ser_line), '0);
    chk("R8 ser_valid", W'(ser_valid), '0);
    chk("R8 rx_data", rx_data, '0);
    chk("R8 rx_valid", W'(rx_valid), '0);
    chk("R6 ref_clk in reset", W'(ref_clk), W'(1));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCYC; k++) begin
      m_exp[k] = (k < NV) ? VEC[k][W] : VEC[NV-1][W];
      w_exp[k] = (k < NV) ? VEC[k][W-1:0] : '0;
      v_exp[k] = (m_exp[k] == ((k == 0) ? 1'b0 : m_exp[k-1]));
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_reset_state();
    rst = 1'b0;

    for (int k = 0; k < NCYC; k++) begin
      for (int j = 0; j < W; j++) begin
        logic [W-1:0] wk;
        logic [W-1:0] e_rx;
        logic         e_ser;
        logic         e_sv;
        wk = w_exp[k];
        // format only counts at tick 0; the inverse elsewhere (R7)
        mode_ddr = (j == 0) ? m_exp[k] : ~m_exp[k];
        if (m_exp[k] == 1'b0) begin
          tx_data = (j == 0) ? wk : ~wk;
        end else if (j == 0) begin
          tx_data = {wk[H-1:0] ^ 5'h15, wk[W-1:H]};
        end else if (j == H) begin
          tx_data = {~wk[W-1:H], wk[H-1:0]};
        end else begin
          tx_data = ~wk;
        end
        @(posedge clk);
        @(negedge clk);

        if (j == W - 1) begin
          e_ser = wk[0];
          e_sv  = v_exp[k];
          chk("R3 first bit out", W'(ser_line), W'(e_ser));
        end else begin
          e_ser = (k >= 1) ? w_exp[k-1][j+1] : 1'b0;
          e_sv  = (k >= 1) ? v_exp[k-1] : 1'b0;
          if (k >= 1 && m_exp[k-1])
            chk("R2 serial bit", W'(ser_line), W'(e_ser));
          else
            chk("R1 serial bit", W'(ser_line), W'(e_ser));
        end
        chk("R7 ser_valid", W'(ser_valid), W'(e_sv));

        if (k < 2) begin
          e_rx = '0;
          chk("R4 rx_data early", rx_data, e_rx);
        end else if (m_exp[k] == 1'b0) begin
          e_rx = w_exp[k-2];
          chk("R4 rx_data wide", rx_data, e_rx);
        end else begin
          e_rx = (j < H) ? W'(w_exp[k-2][W-1:H]) : W'(w_exp[k-2][H-1:0]);
          chk("R5 rx_data half", rx_data, e_rx);
        end
        chk("R7 rx_valid", W'(rx_valid), W'(v_exp[k]));
        chk("R6 ref_clk", W'(ref_clk), W'((j == W - 1) || (j < H - 1)));
      end
    end

    // reset in the middle of traffic
    mode_ddr = 1'b1;
    tx_data  = 10'h3FF;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_reset_state();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule